// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers up to 31 interrupt lines and gives each of several processors a 4-bit interrupt level. That level is the highest-numbered source that is waiting and enabled for that processor. A processor takes an interrupt by returning the level on its acknowledge port. The controller then retires the matching source. Software runs the controller through a small 32-bit register bus with word addresses. The bus has a pending view, a write-one-to-set force register, a write-one-to-clear register, a status word, a broadcast register, and three banks of per-processor registers: enable mask, private force and extended identification.

Sources 1 to 15 are standard lines, and a source's number is also its priority. The trap a processor takes for level n is 0x10 + n, so live traps fall between 0x11 and 0x1F. When the `EXT_EN` parameter is set, sources 16 to 31 are extended sources. They all appear on one standard line chosen by `EXT_LINE`. Each processor's identification register names the highest extended source it has waiting. When `EXT_EN` is clear, bits 16 to 31 are dropped everywhere.

A source marked in the broadcast register does not go into the shared pending word. Its arrival goes into every processor's private force register, so each processor retires its own copy. Source inputs are sampled as levels. A line that is still driven high re-arms its pending bit, so the device must drop it before the pending bit is cleared.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pending word, the broadcast register, every mask, every private force register and every identification register read 0, and every `cpu_irl` is 0.
- R2: A source input sampled high at a clock edge sets its pending bit from that edge. The bit stays set after the input falls. While the input stays high, a clear has no lasting effect.
- R3: Each processor's `cpu_irl` is the highest-numbered standard line in 1..15 that has a request for it, or 0 if none does. A processor has a request on a source when the source is pending or privately forced, and the source's bit in that processor's mask is 1.
- R4: Writing the clear register (word 2) clears every pending bit written as 1. A set from an input or a force in the same cycle takes precedence.
- R5: Writing the force register (word 1) sets every pending bit written as 1, for sources that are not broadcast.
- R6: For a source whose bit in the broadcast register (word 4) is 1, an arrival sets that bit in every private force register (word 16+c) and leaves the pending word unchanged. An acknowledge from processor c clears only processor c's copy.
- R7: An acknowledge with a non-zero level L retires source L. If the acknowledging processor's private force bit L is set, that bit is cleared. Otherwise the shared pending bit L is cleared. Level 0 does nothing.
- R8: With extended mode, any request on sources 16..31 raises line `EXT_LINE` (default 12). The identification register (word 24+c) reads the number of the highest such source, with bit 4 set and the rest 0. It reads 0 when there is none. An acknowledge on `EXT_LINE` retires that extended source first.
- R9: Source 0 is reserved. Its input, its force bit, its clear bit and its broadcast, mask and private-force bits are all ignored and read 0.
- R10: The status register (word 3) reads the processor count minus one in bits 31:28 and 1 in bit 27, with all other bits 0.
- R11: A read returns the addressed register on `bus_rdata` from the edge where `bus_rd` was sampled. The mask registers (word 8+c) read back what was written, except for the bits that R9 and disabled extended mode drop. Unused words read 0, and writes to read-only words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 32 | Source request levels, bit n is source n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| cpu_ack | input | NCPU | Acknowledge strobe per processor |
| cpu_ack_lvl | input | 4*NCPU | Acknowledged level, 4 bits per processor |
| cpu_irl | output | 4*NCPU | Interrupt level, 4 bits per processor |

## Verification
The bench targets the following corner cases, each paired with the fault it exposes:
- **Clear while the input is held high.** Giving the clear priority over the set would lose a live level-triggered request.
- **Acknowledge of a broadcast source.** If the acknowledge cleared the shared bit or every processor's copy, the other processors would miss their interrupt.
- **Acknowledge on the folded line while a higher standard source is waiting.** The extended source must be retired, not the standard line. A design that decoded the level literally would drop the wrong source and leave the identification register stale.
- **Reserved bit 0, the per-processor masks and the status layout.** Each is checked by readback. The bench also compares every processor's level each cycle against a behavioural model driven by random traffic, which catches priority slips and cross-processor leaks.

// File: rtl/mp_irq_pkg.sv
// Shared constants and helpers for the interrupt controller.
// Assumes 32 source lines and a 5-bit word address split as group/index.
package mp_irq_pkg;

    localparam int SRC_W  = 32;
    localparam int LVL_W  = 4;
    localparam int SLOTS  = 8;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_MASK   = 2'd1,
        GRP_LFORCE = 2'd2,
        GRP_ID     = 2'd3
    } reg_grp_e;

    localparam logic [2:0] OFS_PEND   = 3'd0;
    localparam logic [2:0] OFS_FORCE  = 3'd1;
    localparam logic [2:0] OFS_CLEAR  = 3'd2;
    localparam logic [2:0] OFS_STATUS = 3'd3;
    localparam logic [2:0] OFS_BCAST  = 3'd4;

    // Lines that exist: bit 0 is reserved, the upper half only in extended mode.
    function automatic logic [SRC_W-1:0] valid_lines(input bit ext);
        return ext ? 32'hFFFF_FFFE : 32'h0000_FFFE;
    endfunction

    // Highest set bit number of a 32-bit vector, 0 if empty.
    function automatic logic [4:0] top_index(input logic [SRC_W-1:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = 0; i < SRC_W; i++)
            if (v[i]) r = 5'(i);
        return r;
    endfunction

    // Highest set bit number of a 16-bit vector, 0 if empty.
    function automatic logic [LVL_W-1:0] top_level16(input logic [15:0] v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 0; i < 16; i++)
            if (v[i]) r = 4'(i);
        return r;
    endfunction

endpackage

// File: rtl/mp_irq_src_bank.sv
// Shared source state: the pending word and the broadcast register.
// Arrivals (input levels or force writes) on broadcast lines are handed to the
// processor ports through bc_set instead of entering the pending word.
// Assumes cpu_clr is already the OR of every port's retire request.
module mp_irq_src_bank
    import mp_irq_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] irq_in,
    input  logic             frc_we,
    input  logic             clr_we,
    input  logic             bc_we,
    input  logic [SRC_W-1:0] wdata,
    input  logic [SRC_W-1:0] cpu_clr,
    output logic [SRC_W-1:0] pend,
    output logic [SRC_W-1:0] bcast,
    output logic [SRC_W-1:0] bc_set
);

    localparam logic [SRC_W-1:0] VALID = valid_lines(EXT_EN);

    logic [SRC_W-1:0] arrive;
    logic [SRC_W-1:0] set_vec;
    logic [SRC_W-1:0] clr_vec;

    // Split arrivals into shared-pending sets and broadcast hand-offs.
    always_comb begin
        arrive  = (irq_in | (frc_we ? wdata : '0)) & VALID;
        bc_set  = arrive & bcast;
        set_vec = arrive & ~bcast;
        clr_vec = (clr_we ? wdata : '0) | cpu_clr;
    end

    // Pending word update: a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | set_vec;
    end

    // Broadcast register write.
    always_ff @(posedge clk) begin
        if (!rst_n)     bcast <= '0;
        else if (bc_we) bcast <= wdata & VALID;
    end

    // R5
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    // R4
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));

    // R9
    reserved_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[0] && !bcast[0]);

endmodule

// File: rtl/mp_irq_cpu_port.sv
// One processor's view: enable mask, private force word, level resolution,
// extended-source folding and acknowledge decode.
// Assumes EXT_LINE is in 1..15 and acknowledges carry the level last presented.
module mp_irq_cpu_port
    import mp_irq_pkg::*;
#(
    parameter bit          EXT_EN   = 1'b1,
    parameter int unsigned EXT_LINE = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] pend,
    input  logic [SRC_W-1:0] bc_set,
    input  logic             mask_we,
    input  logic             lf_we,
    input  logic [SRC_W-1:0] wdata,
    input  logic             ack,
    input  logic [LVL_W-1:0] ack_lvl,
    output logic [LVL_W-1:0] irl,
    output logic [4:0]       eid,
    output logic [SRC_W-1:0] mask,
    output logic [SRC_W-1:0] lforce,
    output logic [SRC_W-1:0] pend_clr
);

    localparam logic [SRC_W-1:0] VALID   = valid_lines(EXT_EN);
    localparam logic [LVL_W-1:0] EXT_LVL = LVL_W'(EXT_LINE);

    logic [SRC_W-1:0] req;
    logic             ext_any;
    logic [4:0]       ext_top;
    logic [15:0]      std;
    logic [4:0]       tgt;
    logic             hit;
    logic [SRC_W-1:0] lf_clr;

    // Requests this processor may see.
    assign req = (pend | lforce) & mask & VALID;

    // Extended folding is built only when the mode is enabled.
    if (EXT_EN) begin : g_ext
        assign ext_any = |req[SRC_W-1:16];
        assign ext_top = top_index(req & 32'hFFFF_0000);
    end else begin : g_noext
        assign ext_any = 1'b0;
        assign ext_top = '0;
    end

    assign eid = ext_any ? ext_top : '0;

    // Standard-line view with the folded extended line merged in.
    always_comb begin
        std = req[15:0];
        if (ext_any) std[EXT_LINE] = 1'b1;
    end

    assign irl = top_level16(std);

    // Acknowledge decode: pick the source, then the register that holds it.
    always_comb begin
        hit      = ack && (ack_lvl != '0);
        tgt      = (ack_lvl == EXT_LVL && ext_any) ? ext_top : {1'b0, ack_lvl};
        lf_clr   = '0;
        pend_clr = '0;
        if (hit) begin
            if (lforce[tgt]) lf_clr[tgt]   = 1'b1;
            else             pend_clr[tgt] = 1'b1;
        end
    end

    // Mask register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= wdata & VALID;
    end

    // Private force word: broadcast arrivals and direct writes set, own acks clear.
    always_ff @(posedge clk) begin
        if (!rst_n) lforce <= '0;
        else        lforce <= (lforce & ~lf_clr) | bc_set | (lf_we ? (wdata & VALID) : '0);
    end

    // R3
    no_req_no_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (irl == '0));

    // R8
    ext_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eid != '0) |-> (eid[4] && irl >= EXT_LVL));

    // R7
    ack_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && lforce[tgt] && !bc_set[tgt] && !lf_we) |=> !lforce[$past(tgt)]);

endmodule

// File: rtl/mp_irq_ctrl.sv
// Top of the interrupt controller: register bus decode, read mux, the shared
// source bank and one port per processor. Word address bits [4:3] pick a
// group (global, mask, private force, identification), bits [2:0] the word
// or processor. Assumes NCPU is 1..8.
module mp_irq_ctrl
    import mp_irq_pkg::*;
#(
    parameter int unsigned NCPU     = 4,
    parameter bit          EXT_EN   = 1'b1,
    parameter int unsigned EXT_LINE = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           irq_in,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [4:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NCPU-1:0]       cpu_ack,
    input  logic [NCPU*4-1:0]     cpu_ack_lvl,
    output logic [NCPU*4-1:0]     cpu_irl
);

    localparam logic [3:0] CPU_FIELD = 4'(NCPU - 1);

    reg_grp_e         grp;
    logic [2:0]       idx;
    logic             frc_we, clr_we, bc_we;
    logic [SRC_W-1:0] pend, bcast, bc_set, cpu_clr;
    logic [SRC_W-1:0] mask_a   [SLOTS];
    logic [SRC_W-1:0] lf_a     [SLOTS];
    logic [SRC_W-1:0] pclr_a   [SLOTS];
    logic [4:0]       eid_a    [SLOTS];
    logic [31:0]      rd_mux;

    assign grp = reg_grp_e'(bus_addr[4:3]);
    assign idx = bus_addr[2:0];

    // Global write strobes.
    assign frc_we = bus_wr && grp == GRP_GLOBAL && idx == OFS_FORCE;
    assign clr_we = bus_wr && grp == GRP_GLOBAL && idx == OFS_CLEAR;
    assign bc_we  = bus_wr && grp == GRP_GLOBAL && idx == OFS_BCAST;

    // Merge retire requests from every processor.
    always_comb begin
        cpu_clr = '0;
        for (int s = 0; s < SLOTS; s++) cpu_clr |= pclr_a[s];
    end

    mp_irq_src_bank #(.EXT_EN(EXT_EN)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .frc_we  (frc_we),
        .clr_we  (clr_we),
        .bc_we   (bc_we),
        .wdata   (bus_wdata),
        .cpu_clr (cpu_clr),
        .pend    (pend),
        .bcast   (bcast),
        .bc_set  (bc_set)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s < NCPU) begin : g_cpu
            logic [LVL_W-1:0] irl_s;
            mp_irq_cpu_port #(.EXT_EN(EXT_EN), .EXT_LINE(EXT_LINE)) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .pend     (pend),
                .bc_set   (bc_set),
                .mask_we  (bus_wr && grp == GRP_MASK && idx == 3'(s)),
                .lf_we    (bus_wr && grp == GRP_LFORCE && idx == 3'(s)),
                .wdata    (bus_wdata),
                .ack      (cpu_ack[s]),
                .ack_lvl  (cpu_ack_lvl[s*4 +: 4]),
                .irl      (irl_s),
                .eid      (eid_a[s]),
                .mask     (mask_a[s]),
                .lforce   (lf_a[s]),
                .pend_clr (pclr_a[s])
            );
            assign cpu_irl[s*4 +: 4] = irl_s;
        end else begin : g_empty
            assign eid_a[s]  = '0;
            assign mask_a[s] = '0;
            assign lf_a[s]   = '0;
            assign pclr_a[s] = '0;
        end
    end

    // Read multiplexer over all groups.
    always_comb begin
        rd_mux = '0;
        unique case (grp)
            GRP_GLOBAL: begin
                if (idx == OFS_PEND)   rd_mux = pend;
                if (idx == OFS_STATUS) rd_mux = {CPU_FIELD, 1'b1, 27'b0};
                if (idx == OFS_BCAST)  rd_mux = bcast;
            end
            GRP_MASK:   rd_mux = mask_a[idx];
            GRP_LFORCE: rd_mux = lf_a[idx];
            GRP_ID:     rd_mux = {27'b0, eid_a[idx]};
            default:    rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/test_mp_irq_ctrl.sv
module test_mp_irq_ctrl;

    localparam int NC   = 4;
    localparam int EXTL = 12;
    localparam bit [31:0] VAL = 32'hFFFF_FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0]   cpu_ack = '0;
    logic [NC*4-1:0] cpu_ack_lvl = '0;
    logic [NC*4-1:0] cpu_irl;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    mp_irq_ctrl #(.NCPU(NC), .EXT_EN(1'b1), .EXT_LINE(EXTL)) i_mp_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_ack(cpu_ack), .cpu_ack_lvl(cpu_ack_lvl), .cpu_irl(cpu_irl)
    );

    // Behavioural reference state
    bit [31:0] m_pend, m_bc;
    bit [31:0] m_mask [NC];
    bit [31:0] m_lf   [NC];
    bit [31:0] exp_rd;
    bit        rd_seen;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] m_req(int c);
        return (m_pend | m_lf[c]) & m_mask[c] & VAL;
    endfunction

    function automatic int m_id(int c);
        bit [31:0] r = m_req(c);
        int id = 0;
        for (int s = 16; s < 32; s++) if (r[s]) id = s;
        return id;
    endfunction

    function automatic int m_irl(int c);
        bit [31:0] r = m_req(c);
        int best = 0;
        for (int s = 1; s < 16; s++)
            if (r[s] || (s == EXTL && m_id(c) != 0)) best = s;
        return best;
    endfunction

    function automatic bit [31:0] m_read(bit [4:0] a);
        int i = a[2:0];
        case (a[4:3])
            2'd0: begin
                if (i == 0) return m_pend;
                if (i == 3) return {4'(NC - 1), 1'b1, 27'b0};
                if (i == 4) return m_bc;
                return 0;
            end
            2'd1: return (i < NC) ? m_mask[i] : 0;
            2'd2: return (i < NC) ? m_lf[i] : 0;
            default: return (i < NC) ? 32'(m_id(i)) : 0;
        endcase
    endfunction

    // Advance the reference by one clock from the inputs currently driven.
    task automatic model_step();
        bit [31:0] clr_p, setv;
        bit [31:0] clr_l [NC];
        rd_seen = 1'b0;
        if (!rst_n) begin
            m_pend = 0; m_bc = 0; exp_rd = 0;
            for (int c = 0; c < NC; c++) begin m_mask[c] = 0; m_lf[c] = 0; end
            return;
        end
        if (bus_rd) begin exp_rd = m_read(bus_addr); rd_seen = 1'b1; end
        clr_p = 0;
        for (int c = 0; c < NC; c++) begin
            int lvl = cpu_ack_lvl[c*4 +: 4];
            int t;
            clr_l[c] = 0;
            if (cpu_ack[c] && lvl != 0) begin
                t = (lvl == EXTL && m_id(c) != 0) ? m_id(c) : lvl;
                if (m_lf[c][t]) clr_l[c][t] = 1'b1;
                else            clr_p[t] = 1'b1;
            end
        end
        setv = (irq_in | ((bus_wr && bus_addr == 5'd1) ? bus_wdata : 0)) & VAL;
        if (bus_wr && bus_addr == 5'd2) clr_p |= bus_wdata;
        for (int c = 0; c < NC; c++) begin
            m_lf[c] = (m_lf[c] & ~clr_l[c]) | (setv & m_bc);
            if (bus_wr && bus_addr == 5'(16 + c)) m_lf[c] |= bus_wdata & VAL;
            if (bus_wr && bus_addr == 5'(8 + c))  m_mask[c] = bus_wdata & VAL;
        end
        m_pend = (m_pend & ~clr_p) | (setv & ~m_bc);
        if (bus_wr && bus_addr == 5'd4) m_bc = bus_wdata & VAL;
    endtask

    // Compare every processor level each cycle, and read data after reads.
    task automatic compare();
        for (int c = 0; c < NC; c++)
            chk(cpu_irl[c*4 +: 4] == 4'(m_irl(c)), "R3 level", cpu_irl[c*4 +: 4], m_irl(c));
        if (rd_seen) chk(bus_rdata == exp_rd, "R11 readback", bus_rdata, exp_rd);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input bit [4:0] a, input bit [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input bit [4:0] a, input bit [31:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
        chk(bus_rdata == e, tag, bus_rdata, e);
    endtask

    task automatic irl_expect(input int c, input int e, input string tag);
        chk(cpu_irl[c*4 +: 4] == 4'(e), tag, cpu_irl[c*4 +: 4], e);
    endtask

    task automatic ack_once(input int c, input int lvl);
        cpu_ack[c] = 1'b1; cpu_ack_lvl[c*4 +: 4] = 4'(lvl);
        tick();
        cpu_ack[c] = 1'b0; cpu_ack_lvl[c*4 +: 4] = '0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        for (int c = 0; c < NC; c++) irl_expect(c, 0, "R1 level after reset");
        rd_expect(5'd0, 0, "R1 pending after reset");
        rd_expect(5'd4, 0, "R1 broadcast after reset");
        rd_expect(5'd8, 0, "R1 mask after reset");
        rd_expect(5'd16, 0, "R1 private force after reset");
        rd_expect(5'd24, 0, "R1 id after reset");
        // R10: status layout
        rd_expect(5'd3, 32'h3800_0000, "R10 status");
        // R11 / R9: masks, bit 0 dropped
        wr(5'd8, 32'hFFFF_FFFF);
        wr(5'd9, 32'h0000_00F0);
        wr(5'd11, 32'hFFFF_0000);
        rd_expect(5'd8, 32'hFFFF_FFFE, "R9 mask bit0 dropped");
        rd_expect(5'd9, 32'h0000_00F0, "R11 mask readback");
        wr(5'd3, 32'h1234_5678);
        rd_expect(5'd3, 32'h3800_0000, "R11 status write ignored");
        // R2 / R3: input pulses, priority and masks
        irq_in = 32'h8; tick(); irq_in = 0; tick();
        irl_expect(0, 3, "R3 cpu0 level 3");
        irl_expect(1, 0, "R3 cpu1 masked");
        rd_expect(5'd0, 32'h8, "R2 pending held after input falls");
        irq_in = 32'h80; tick(); irq_in = 0;
        irl_expect(0, 7, "R3 cpu0 highest wins");
        irl_expect(1, 7, "R3 cpu1 enabled line");
        // R5 / R9: force, reserved bit ignored
        wr(5'd1, 32'h0000_0201);
        rd_expect(5'd0, 32'h288, "R5 force sets pending R9 bit0 ignored");
        irl_expect(0, 9, "R3 cpu0 forced line");
        // R7: ack clears shared pending
        ack_once(0, 9);
        rd_expect(5'd0, 32'h88, "R7 ack clears pending");
        ack_once(0, 0);
        rd_expect(5'd0, 32'h88, "R7 level 0 ack ignored");
        // R4: clear, and set wins in same cycle
        wr(5'd2, 32'h88);
        rd_expect(5'd0, 0, "R4 clear");
        irq_in = 32'h20; wr(5'd2, 32'h20); irq_in = 0;
        rd_expect(5'd0, 32'h20, "R4 set wins over clear");
        wr(5'd2, 32'h20);
        // R2: level still high re-arms
        irq_in = 32'h40; tick();
        wr(5'd2, 32'h40);
        rd_expect(5'd0, 32'h40, "R2 clear while input high");
        irq_in = 0; tick();
        wr(5'd2, 32'h40);
        rd_expect(5'd0, 0, "R2 clear after input falls");
        // R6: broadcast
        wr(5'd4, 32'h400);
        wr(5'd1, 32'h400);
        rd_expect(5'd0, 0, "R6 broadcast skips pending");
        rd_expect(5'd17, 32'h400, "R6 copy in cpu1");
        irl_expect(0, 10, "R6 cpu0 sees copy");
        ack_once(0, 10);
        rd_expect(5'd16, 0, "R6 cpu0 copy retired");
        rd_expect(5'd17, 32'h400, "R6 cpu1 copy kept");
        for (int c = 1; c < NC; c++) ack_once(c, 10);
        wr(5'd4, 0);
        // R8: extended folding
        wr(5'd1, 32'h0810_0000);
        irl_expect(0, EXTL, "R8 folded line cpu0");
        irl_expect(3, EXTL, "R8 folded line cpu3");
        rd_expect(5'd24, 27, "R8 id cpu0");
        rd_expect(5'd27, 27, "R8 id cpu3");
        rd_expect(5'd25, 0, "R8 id cpu1 none");
        wr(5'd1, 32'h4000);
        irl_expect(0, 14, "R8 standard above folded");
        ack_once(0, EXTL);
        rd_expect(5'd24, 20, "R8 ack retires extended");
        irl_expect(0, 14, "R8 standard kept");
        wr(5'd2, 32'h4000);
        irl_expect(0, EXTL, "R8 folded after clear");
        ack_once(0, EXTL);
        rd_expect(5'd24, 0, "R8 id empty");
        irl_expect(0, 0, "R8 no level left");
        // Random traffic against the reference
        for (int n = 0; n < 600; n++) begin
            irq_in = $urandom & $urandom & $urandom;
            for (int c = 0; c < NC; c++)
                if ($urandom % 3 == 0) begin
                    cpu_ack[c] = 1'b1;
                    cpu_ack_lvl[c*4 +: 4] = 4'(($urandom % 8 == 0) ? $urandom % 16 : m_irl(c));
                end
            case ($urandom % 6)
                0: begin bus_wr = 1'b1; bus_addr = 5'($urandom); bus_wdata = $urandom; end
                1: begin bus_rd = 1'b1; bus_addr = 5'($urandom); end
                2: begin bus_wr = 1'b1; bus_addr = 5'd2; bus_wdata = $urandom; end
                default: ;
            endcase
            tick();
            bus_wr = 1'b0; bus_rd = 1'b0; cpu_ack = '0; cpu_ack_lvl = '0;
        end
        irq_in = 0;
        tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule